// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Program-Cycle Sequencer

This block sits between the command decoder of a serial EEPROM and its storage array. It holds the erase/write enable latch, which comes out of reset in the disabled state and is changed only by the enable and disable commands. A write request that arrives while the latch is enabled and no program cycle is running is accepted. Its address and data are captured, and a self-timed program interval starts, counted in system-clock cycles. At the end of the interval the block issues one commit strobe to the array.

From the moment a write is accepted, the block reports status on the serial data-out pin: 0 while the program cycle runs and 1 once it is complete. The status is driven only while chip select is high, and the pin is released otherwise. Status reporting stays armed across chip-select toggles until the decoder signals the start bit of the next instruction. Write, enable and disable commands that arrive during a program cycle are dropped. Reads do not pass through this block, so the latch has no effect on them.

Top module: `wp_prog_seq`

## Requirements
- R1: During and after synchronous reset the enable latch is cleared, `busy_o` is 0, `do_oe_o` is 0 and `commit_o` is 0.
- R2: A `wr_req_i` pulse while the latch is disabled is ignored: `busy_o` stays 0, no commit occurs and the status is not armed.
- R3: A `wen_cmd_i` pulse enables the latch. It stays enabled across any number of writes until a `wds_cmd_i` pulse disables it, after which writes are ignored as in R2.
- R4: An accepted write raises `busy_o` on the clock edge that samples the request. `busy_o` stays high for exactly `PROG_CYCLES` clock cycles.
- R5: While the status is enabled on the pin, `do_o` is 0 during the program cycle and 1 after it ends.
- R6: `commit_o` is high for exactly one cycle, the first cycle after `busy_o` falls. It carries the address and data sampled with the accepted request.
- R7: `do_oe_o` follows chip select with one register stage. It is 0 whenever chip select was low at the previous edge.
- R8: Once a write is accepted, the status is driven whenever chip select is high, across any number of chip-select toggles, until a `start_bit_i` pulse disarms it.
- R9: `wr_req_i`, `wen_cmd_i` and `wds_cmd_i` pulses that arrive while `busy_o` is high have no effect on the latch, the timer or the captured write.
- R10: If enable and disable pulses arrive in the same cycle, the latch ends up disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cs_i | input | 1 | Chip select, high = selected |
| start_bit_i | input | 1 | One-cycle pulse: start bit of a new instruction seen |
| wr_req_i | input | 1 | One-cycle pulse: last data bit of a write clocked in |
| wr_addr_i | input | AW | Write address, valid with `wr_req_i` |
| wr_data_i | input | DW | Write data, valid with `wr_req_i` |
| wen_cmd_i | input | 1 | One-cycle pulse: enable command decoded |
| wds_cmd_i | input | 1 | One-cycle pulse: disable command decoded |
| commit_o | output | 1 | One-cycle strobe to the array to store the captured word |
| commit_addr_o | output | AW | Address for the commit |
| commit_data_o | output | DW | Data for the commit |
| busy_o | output | 1 | Program cycle in progress |
| do_o | output | 1 | Status value for the data-out pin (0 busy, 1 ready) |
| do_oe_o | output | 1 | Output enable for the data-out pin |

## Verification
The bench counts the length of the busy window exactly. A timer that is off by one would stretch or shorten the program interval and move the commit strobe. It sends writes, enables and disables into the busy window. A design that does not gate them would restart the timer, overwrite the captured address, or change the latch state seen by the next write. It toggles chip select after completion and then sends a start bit. A design that ties status to the program cycle instead of to the start bit would go quiet too early, and one that ignores chip select would drive a pin it does not own. Simultaneous enable and disable pulses check that disable takes priority.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [1:0] {
    LC_HOLD = 2'd0,
    LC_SET  = 2'd1,
    LC_CLR  = 2'd2
  } latch_cmd_e;

  function automatic latch_cmd_e pick_latch_cmd(input logic set_req,
                                                input logic clr_req,
                                                input logic blocked);
    if (blocked)      return LC_HOLD;
    else if (clr_req) return LC_CLR;
    else if (set_req) return LC_SET;
    else              return LC_HOLD;
  endfunction

endpackage

// File: rtl/wps_enable_latch.sv
module wps_enable_latch
  import wps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic set_req_i,
  input  logic clr_req_i,
  output logic en_o
);

  latch_cmd_e cmd;
  logic       en_q;

  always_comb begin
    cmd = pick_latch_cmd(set_req_i, clr_req_i, busy_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else begin
      unique case (cmd)
        LC_SET:  en_q <= 1'b1;
        LC_CLR:  en_q <= 1'b0;
        default: en_q <= en_q;
      endcase
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/wps_prog_timer.sv
module wps_prog_timer #(
  parameter int PROG_CYCLES = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PROG_CYCLES);
  localparam logic [CW-1:0] LAST_VAL = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          last;

  assign last   = busy_q && (cnt_q == LAST_VAL);
  assign done_o = last;
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        cnt_q  <= LOAD_VAL;
        busy_q <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - LAST_VAL;
      if (last) begin
        busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wps_write_capture.sv
module wps_write_capture #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          done_i,
  output logic          commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          commit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) commit_q <= 1'b0;
    else     commit_q <= done_i;
  end

  assign commit_o      = commit_q;
  assign commit_addr_o = addr_q;
  assign commit_data_o = data_q;

endmodule

// File: rtl/wps_status_drv.sv
module wps_status_drv (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic start_bit_i,
  input  logic accept_i,
  input  logic done_i,
  output logic do_o,
  output logic do_oe_o
);

  logic armed_q, armed_d;
  logic rdy_q, rdy_d;
  logic do_q, oe_q;

  always_comb begin
    armed_d = armed_q;
    if (accept_i)         armed_d = 1'b1;
    else if (start_bit_i) armed_d = 1'b0;
    rdy_d = rdy_q;
    if (accept_i)         rdy_d = 1'b0;
    else if (done_i)      rdy_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      rdy_q   <= 1'b1;
      oe_q    <= 1'b0;
      do_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      rdy_q   <= rdy_d;
      oe_q    <= cs_i && armed_d;
      do_q    <= cs_i && armed_d && rdy_d;
    end
  end

  assign do_o    = do_q;
  assign do_oe_o = oe_q;

endmodule

// File: rtl/wp_prog_seq.sv
module wp_prog_seq #(
  parameter int AW          = 10,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 400000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_i,
  input  logic          start_bit_i,
  input  logic          wr_req_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wen_cmd_i,
  input  logic          wds_cmd_i,
  output logic          commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o,
  output logic          busy_o,
  output logic          do_o,
  output logic          do_oe_o
);

  logic en_q;
  logic busy;
  logic done;
  logic accept;

  assign accept = wr_req_i && en_q && !busy;
  assign busy_o = busy;

  wps_enable_latch i_latch (
    .clk       (clk),
    .rst       (rst),
    .busy_i    (busy),
    .set_req_i (wen_cmd_i),
    .clr_req_i (wds_cmd_i),
    .en_o      (en_q)
  );

  wps_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (accept),
    .busy_o  (busy),
    .done_o  (done)
  );

  wps_write_capture #(.AW(AW), .DW(DW)) i_cap (
    .clk           (clk),
    .rst           (rst),
    .accept_i      (accept),
    .addr_i        (wr_addr_i),
    .data_i        (wr_data_i),
    .done_i        (done),
    .commit_o      (commit_o),
    .commit_addr_o (commit_addr_o),
    .commit_data_o (commit_data_o)
  );

  wps_status_drv i_stat (
    .clk         (clk),
    .rst         (rst),
    .cs_i        (cs_i),
    .start_bit_i (start_bit_i),
    .accept_i    (accept),
    .done_i      (done),
    .do_o        (do_o),
    .do_oe_o     (do_oe_o)
  );

endmodule

// File: rtl/wps_checker.sv
module wps_checker (
  input logic clk,
  input logic rst,
  input logic cs_i,
  input logic wr_req_i,
  input logic wen_cmd_i,
  input logic wds_cmd_i,
  input logic en_q,
  input logic busy_o,
  input logic commit_o,
  input logic do_o,
  input logic do_oe_o
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!en_q && !busy_o && !do_oe_o && !commit_o));

  a_r2_disabled_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_req_i && !en_q && !busy_o) |=> !busy_o);

  a_r5_busy_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (do_oe_o && busy_o) |-> !do_o);

  a_r5_ready_reads_one: assert property (@(posedge clk) disable iff (rst)
    (do_oe_o && !busy_o) |-> do_o);

  a_r6_single_commit: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  a_r6_commit_after_busy: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $fell(busy_o));

  a_r7_released_without_cs: assert property (@(posedge clk) disable iff (rst)
    !$past(cs_i) |-> !do_oe_o);

  a_r9_latch_frozen_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (wen_cmd_i || wds_cmd_i)) |=> (en_q == $past(en_q)));

  a_r10_disable_wins: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && wen_cmd_i && wds_cmd_i) |=> !en_q);

endmodule

bind wp_prog_seq wps_checker i_wps_checker (
  .clk       (clk),
  .rst       (rst),
  .cs_i      (cs_i),
  .wr_req_i  (wr_req_i),
  .wen_cmd_i (wen_cmd_i),
  .wds_cmd_i (wds_cmd_i),
  .en_q      (en_q),
  .busy_o    (busy_o),
  .commit_o  (commit_o),
  .do_o      (do_o),
  .do_oe_o   (do_oe_o)
);

// File: tb/test_wp_prog_seq.sv
`timescale 1ns/1ps
module test_wp_prog_seq;

  localparam int AW = 10;
  localparam int DW = 16;
  localparam int PROG = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_i = 1'b0;
  logic          start_bit_i = 1'b0;
  logic          wr_req_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          wen_cmd_i = 1'b0;
  logic          wds_cmd_i = 1'b0;
  logic          commit_o;
  logic [AW-1:0] commit_addr_o;
  logic [DW-1:0] commit_data_o;
  logic          busy_o;
  logic          do_o;
  logic          do_oe_o;

  int n_run = 0;
  int n_fail = 0;
  int n_commit = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;

  always #10 clk = ~clk;

  wp_prog_seq #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG)) i_wp_prog_seq (
    .clk(clk), .rst(rst), .cs_i(cs_i), .start_bit_i(start_bit_i),
    .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wen_cmd_i(wen_cmd_i), .wds_cmd_i(wds_cmd_i),
    .commit_o(commit_o), .commit_addr_o(commit_addr_o),
    .commit_data_o(commit_data_o), .busy_o(busy_o),
    .do_o(do_o), .do_oe_o(do_oe_o)
  );

  always @(negedge clk) begin
    if (!rst && commit_o) begin
      n_commit++;
      last_addr = commit_addr_o;
      last_data = commit_data_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wen();
    @(negedge clk); wen_cmd_i = 1'b1;
    @(negedge clk); wen_cmd_i = 1'b0;
  endtask

  task automatic pulse_wds();
    @(negedge clk); wds_cmd_i = 1'b1;
    @(negedge clk); wds_cmd_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_bit_i = 1'b1;
    @(negedge clk); start_bit_i = 1'b0;
  endtask

  task automatic pulse_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_req_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk); wr_req_i = 1'b0;
  endtask

  // count busy cycles until it drops; returns count
  task automatic wait_done(output int len);
    len = 0;
    while (busy_o && len < PROG + 10) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 busy", busy_o, 0);
    check("R1 oe", do_oe_o, 0);
    check("R1 commit", commit_o, 0);
  endtask

  task automatic t_disabled_write();
    int c0;
    c0 = n_commit;
    cs_i = 1'b1;
    pulse_write(10'h011, 16'h1111);
    check("R2 busy", busy_o, 0);
    idle(PROG + 4);
    check("R2 commit count", n_commit - c0, 0);
    check("R2 status not armed", do_oe_o, 0);
  endtask

  task automatic t_enabled_write();
    int len, c0;
    c0 = n_commit;
    pulse_wen();
    pulse_write(10'h2A5, 16'hBEEF);
    check("R4 busy rises", busy_o, 1);
    check("R5 busy value", do_o, 0);
    check("R7 oe with cs", do_oe_o, 1);
    wait_done(len);
    check("R4 busy length", len, PROG);
    check("R6 commit now", commit_o, 1);
    check("R6 commit addr", commit_addr_o, 10'h2A5);
    check("R6 commit data", commit_data_o, 16'hBEEF);
    idle(1);
    check("R6 single commit", n_commit - c0, 1);
    check("R5 ready value", do_o, 1);
  endtask

  task automatic t_cs_toggle();
    @(negedge clk); cs_i = 1'b0;
    @(negedge clk);
    check("R7 released", do_oe_o, 0);
    idle(3);
    @(negedge clk); cs_i = 1'b1;
    @(negedge clk);
    check("R8 status back oe", do_oe_o, 1);
    check("R8 status back value", do_o, 1);
    pulse_start();
    check("R8 start releases", do_oe_o, 0);
    idle(3);
    check("R8 stays released", do_oe_o, 0);
  endtask

  task automatic t_busy_ignores();
    int len, c0;
    c0 = n_commit;
    pulse_write(10'h0C3, 16'h1234);
    check("R3 latch persists", busy_o, 1);
    idle(3);
    pulse_write(10'h3FF, 16'hFFFF);
    pulse_wds();
    wait_done(len);
    check("R9 timer not restarted", len, PROG - 3 - 4);
    idle(1);
    check("R9 one commit", n_commit - c0, 1);
    check("R9 first addr kept", last_addr, 10'h0C3);
    check("R9 first data kept", last_data, 16'h1234);
    pulse_write(10'h001, 16'h0001);
    check("R9 disable during busy dropped", busy_o, 1);
    wait_done(len);
    idle(2);
  endtask

  task automatic t_disable();
    pulse_wds();
    pulse_write(10'h002, 16'h0002);
    check("R3 disabled after wds", busy_o, 0);
  endtask

  task automatic t_both();
    pulse_wen();
    @(negedge clk); wen_cmd_i = 1'b1; wds_cmd_i = 1'b1;
    @(negedge clk); wen_cmd_i = 1'b0; wds_cmd_i = 1'b0;
    pulse_write(10'h003, 16'h0003);
    check("R10 disable wins", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);
    t_reset();
    t_disabled_write();
    t_enabled_write();
    t_cs_toggle();
    t_busy_ignores();
    t_disable();
    t_both();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule